// File: doc/BRIEF.md
# Dual Linkable Interval Timer

This block holds two independent down-counting interval timers, A and B. Each timer has a reload latch that can only be written, a counter that can only be read, and a control register. The host reaches all of them through a byte-wide register bus with an address, write data, a write strobe and a read strobe. Each timer counts one of several selected events. The events are a system tick input, rising edges of an external count pin (after a synchroniser), and, for timer B only, underflows of timer A, optionally gated by the count pin level.

When a counter is at zero and a count event arrives, the timer underflows. The counter reloads from the latch and the timer's interrupt flag is set. In one-shot mode the timer then stops itself. Each timer drives one port output bit, either as a toggle or as a one-cycle pulse. It also drives an output-enable flag that overrides the port's direction when the routing bit is set. Timer A drives port line 6 and timer B drives port line 7.

Register map (3-bit address): 0/1 timer A low/high byte, 2/3 timer B low/high byte, 4 timer A control, 5 timer B control, 6 status. Control byte: bit0 run, bit1 port routing enable, bit2 output style (1 toggle, 0 pulse), bit3 one-shot, bit4 force-load strobe, bits6:5 event source.

Top module: `dual_interval_timer`

## Requirements
- R1: A read of address 0/1 (A) or 2/3 (B) returns the live counter low/high byte. Address 4/5 returns the control byte with bit4 always 0. Address 6 returns {6'b0, flag_b, flag_a}.
- R2: Writes to the low and high byte addresses update the latch. A high-byte write to a stopped timer also loads the whole new latch value into the counter on the same edge.
- R3: A high-byte write to a running timer updates the latch only and leaves the counter counting.
- R4: A running timer decrements once per selected event. An event with the counter at 0 is an underflow and reloads the latch, so one period is latch+1 events.
- R5: In one-shot mode (bit3=1) an underflow clears the run bit, and the counter holds the reloaded latch value.
- R6: In continuous mode (bit3=0) the timer keeps running across underflows.
- R7: Writing a control byte with bit4=1 copies the latch into the counter at once, whether the timer is running or not.
- R8: A stopped timer's counter does not change on count events.
- R9: An underflow sets that timer's interrupt flag. A read strobe on the status address clears both flags.
- R10: In pulse style the port bit is high for exactly the one cycle after each underflow.
- R11: In toggle style the port bit goes high when a control write takes the run bit from 0 to 1, and inverts on every underflow.
- R12: Control bit1 drives the port output-enable flag of that timer (pb_oe[0] for A, pb_oe[1] for B).
- R13: Source codes: A uses 0 tick, 1 or 3 count-pin rising edges, 2 tick. B uses 0 tick, 1 count-pin rising edges, 2 timer A underflows, 3 timer A underflows while the synchronised count pin is high.
- R14: After reset both counters and latches are all ones, control bytes are 0, and flags and port outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | System count enable, one event per high cycle |
| cnt_pin | input | 1 | External count pin, asynchronous |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears flags on the status address) |
| rdata | output | 8 | Read data, combinational from addr |
| irq_a | output | 1 | Timer A underflow flag |
| irq_b | output | 1 | Timer B underflow flag |
| pb_out | output | 2 | Port bits: [0] line 6 from A, [1] line 7 from B |
| pb_oe | output | 2 | Output-enable overrides for the two port lines |

## Verification
The hardest state to reach is timer B counting timer A underflows while the gate depends on the synchronised pin level. Reaching it needs A reloading continuously, B configured for chaining, and the pin held through the synchroniser delay before ticks are applied. The bench sets A to a latch of 1 so that underflows come every second tick, and checks B's count with the pin low and then high. Random latch values and tick counts drive timer A through many wraps, and bench functions predict the counter, toggle level and flag from the latch and event count.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int unsigned REG_A_LO = 0;
   localparam int unsigned REG_A_HI = 1;
   localparam int unsigned REG_B_LO = 2;
   localparam int unsigned REG_B_HI = 3;
   localparam int unsigned REG_A_CTL = 4;
   localparam int unsigned REG_B_CTL = 5;
   localparam int unsigned REG_STAT = 6;

   localparam logic [1:0] SRC_TICK = 2'd0;
   localparam logic [1:0] SRC_PIN = 2'd1;
   localparam logic [1:0] SRC_CHAIN = 2'd2;
   localparam logic [1:0] SRC_GATED = 2'd3;

   typedef struct packed {
      logic [1:0] src;
      logic       force_ld;
      logic       one_shot;
      logic       toggle;
      logic       port_en;
      logic       run;
   } tmr_ctl_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level = sync_q[STAGES-1];
   assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/timer_core.sv
module timer_core
   import timer_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_ev,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic         wr_ctl,
   input  logic [7:0]   wdata,
   output logic [W-1:0] count,
   output logic [W-1:0] latch_o,
   output tmr_ctl_t     ctl,
   output logic         uf,
   output logic         port_o
);
   localparam int unsigned HI_W = W - 8;

   if (W < 9 || W > 16) begin : g_bad_width
      $error("timer_core: W must lie in 9..16");
   end

   logic [W-1:0] lat_q, cnt_q;
   tmr_ctl_t     ctl_q, new_ctl;
   logic         tog_q, pls_q;

   assign new_ctl = tmr_ctl_t'(wdata[6:0]);
   assign uf      = ctl_q.run & cnt_ev & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '1;
         cnt_q <= '1;
         ctl_q <= '0;
         tog_q <= 1'b0;
         pls_q <= 1'b0;
      end else begin
         if (wr_lo) lat_q[7:0] <= wdata;
         if (wr_hi) lat_q[W-1:8] <= wdata[HI_W-1:0];

         if (wr_ctl && new_ctl.force_ld)        cnt_q <= lat_q;
         else if (wr_hi && !ctl_q.run)          cnt_q <= {wdata[HI_W-1:0], lat_q[7:0]};
         else if (uf)                           cnt_q <= lat_q;
         else if (ctl_q.run && cnt_ev)          cnt_q <= cnt_q - 1'b1;

         if (wr_ctl) begin
            ctl_q          <= new_ctl;
            ctl_q.force_ld <= 1'b0;
         end else if (uf && ctl_q.one_shot) begin
            ctl_q.run <= 1'b0;
         end

         if (wr_ctl && new_ctl.run && !ctl_q.run) tog_q <= 1'b1;
         else if (uf)                            tog_q <= ~tog_q;

         pls_q <= uf;
      end
   end

   assign count   = cnt_q;
   assign latch_o = lat_q;
   assign ctl     = ctl_q;
   assign port_o  = ctl_q.toggle ? tog_q : pls_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import timer_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cnt_pin,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [7:0]        rdata,
   output logic              irq_a,
   output logic              irq_b,
   output logic [1:0]        pb_out,
   output logic [1:0]        pb_oe
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dual_interval_timer: ADDR_W must be at least 3");
   end

   logic         pin_lvl, pin_rise;
   logic         ev_a, ev_b, uf_a, uf_b;
   logic [W-1:0] cnt_a, cnt_b, lat_a, lat_b;
   tmr_ctl_t     ctl_a, ctl_b;
   logic [15:0]  cnt_a16, cnt_b16;
   logic [1:0]   irq_q;
   logic         stat_clr;

   pin_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(pin_lvl), .rise(pin_rise)
   );

   assign ev_a = ctl_a.src[0] ? pin_rise : tick;

   always_comb begin
      unique case (ctl_b.src)
         SRC_TICK:  ev_b = tick;
         SRC_PIN:   ev_b = pin_rise;
         SRC_CHAIN: ev_b = uf_a;
         default:   ev_b = uf_a & pin_lvl;
      endcase
   end

   timer_core #(.W(W)) u_tmr_a (
      .clk(clk), .rst_n(rst_n), .cnt_ev(ev_a),
      .wr_lo(wr_en && addr == ADDR_W'(REG_A_LO)),
      .wr_hi(wr_en && addr == ADDR_W'(REG_A_HI)),
      .wr_ctl(wr_en && addr == ADDR_W'(REG_A_CTL)),
      .wdata(wdata), .count(cnt_a), .latch_o(lat_a), .ctl(ctl_a),
      .uf(uf_a), .port_o(pb_out[0])
   );

   timer_core #(.W(W)) u_tmr_b (
      .clk(clk), .rst_n(rst_n), .cnt_ev(ev_b),
      .wr_lo(wr_en && addr == ADDR_W'(REG_B_LO)),
      .wr_hi(wr_en && addr == ADDR_W'(REG_B_HI)),
      .wr_ctl(wr_en && addr == ADDR_W'(REG_B_CTL)),
      .wdata(wdata), .count(cnt_b), .latch_o(lat_b), .ctl(ctl_b),
      .uf(uf_b), .port_o(pb_out[1])
   );

   assign stat_clr = rd_en && addr == ADDR_W'(REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= {uf_b, uf_a} | (irq_q & {2{~stat_clr}});
   end

   assign cnt_a16 = 16'(cnt_a);
   assign cnt_b16 = 16'(cnt_b);

   always_comb begin
      unique case (addr)
         ADDR_W'(REG_A_LO):  rdata = cnt_a16[7:0];
         ADDR_W'(REG_A_HI):  rdata = cnt_a16[15:8];
         ADDR_W'(REG_B_LO):  rdata = cnt_b16[7:0];
         ADDR_W'(REG_B_HI):  rdata = cnt_b16[15:8];
         ADDR_W'(REG_A_CTL): rdata = {1'b0, ctl_a};
         ADDR_W'(REG_B_CTL): rdata = {1'b0, ctl_b};
         ADDR_W'(REG_STAT):  rdata = {6'b0, irq_q};
         default:            rdata = 8'h00;
      endcase
   end

   assign irq_a = irq_q[0];
   assign irq_b = irq_q[1];
   assign pb_oe = {ctl_b.port_en, ctl_a.port_en};
endmodule

// File: rtl/timer_chk.sv
module timer_chk
   import timer_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [W-1:0]      cnt_a,
   input logic [W-1:0]      lat_a,
   input logic              run_a,
   input logic              os_a,
   input logic              uf_a,
   input logic              uf_b,
   input logic              irq_a,
   input logic              irq_b
);
   // R4: every underflow reloads the counter from the latch held before the edge
   assert_reload_on_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uf_a |=> cnt_a == $past(lat_a));

   // R5: a one-shot underflow without a competing control write stops the timer
   assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_a && os_a && !(wr_en && addr == ADDR_W'(REG_A_CTL))) |=> !run_a);

   // R8: no bus write and not running means the counter holds
   assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_a && !wr_en) |=> $stable(cnt_a));

   // R9: underflow raises the flag of the same timer
   assert_flag_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uf_a |=> irq_a);
   assert_flag_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uf_b |=> irq_b);

   // R9: a flag only rises after an underflow
   assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_a) |-> $past(uf_a));
endmodule

bind dual_interval_timer timer_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .cnt_a(cnt_a), .lat_a(lat_a), .run_a(ctl_a.run), .os_a(ctl_a.one_shot),
   .uf_a(uf_a), .uf_b(uf_b), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] C_RUN = 8'h01, C_PE = 8'h02, C_TOG = 8'h04,
                          C_ONE = 8'h08, C_FRC = 8'h10;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cnt_pin = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic       irq_a, irq_b;
   logic [1:0] pb_out, pb_oe;
   int checks = 0, errors = 0;

   dual_interval_timer i_dual_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .addr(addr),
      .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
      .irq_a(irq_a), .irq_b(irq_b), .pb_out(pb_out), .pb_oe(pb_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int exp_count(input int lat, input int n);
      return lat - (n % (lat + 1));
   endfunction

   function automatic int exp_wraps(input int lat, input int n);
      return n / (lat + 1);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic rd16(input logic [2:0] a, output int v);
      logic [7:0] lo, hi;
      rd(a, lo); rd(a + 3'd1, hi);
      v = {hi, lo};
   endtask

   task automatic run_ticks(input int n);
      if (n > 0) begin
         @(negedge clk); tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic load_a(input int v);
      wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      logic [7:0] b;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R14 reset state
      rd16(3'd0, v); chk("R14 counter A reset", v, 16'hffff);
      rd16(3'd2, v); chk("R14 counter B reset", v, 16'hffff);
      rd(3'd4, b);   chk("R14 ctl A reset", b, 0);
      chk("R14 port/oe/flags reset", {pb_out, pb_oe, irq_b, irq_a}, 0);

      // R2 stopped high write loads counter
      load_a(16'h1234);
      rd16(3'd0, v); chk("R2 stopped load", v, 16'h1234);
      // R3 running high write keeps counter
      wr(3'd4, C_RUN);
      wr(3'd1, 8'h56);
      rd16(3'd0, v); chk("R3 running high write", v, 16'h1234);
      // R7 force load, R1 strobe reads 0
      wr(3'd4, C_RUN | C_FRC);
      rd16(3'd0, v); chk("R7 force load", v, 16'h5634);
      rd(3'd4, b);   chk("R1 ctl readback strobe clear", b, C_RUN);
      // R8 stopped ignores ticks
      wr(3'd4, 8'h00);
      run_ticks(5);
      rd16(3'd0, v); chk("R8 stopped hold", v, 16'h5634);

      // R5/R10/R12 one-shot pulse
      load_a(3);
      rd(3'd6, b);
      wr(3'd4, C_RUN | C_PE | C_ONE);
      chk("R12 oe A", pb_oe, 2'b01);
      @(negedge clk); tick = 1'b1;
      repeat (3) @(negedge clk);
      #1 chk("R10 no pulse before underflow", pb_out[0], 0);
      @(negedge clk); tick = 1'b0;
      #1 chk("R10 pulse high after underflow", pb_out[0], 1);
      @(negedge clk);
      #1 chk("R10 pulse one cycle", pb_out[0], 0);
      rd(3'd4, b);   chk("R5 run cleared", b & C_RUN, 0);
      rd16(3'd0, v); chk("R5 counter reloaded", v, 3);
      chk("R9 flag set", irq_a, 1);
      rd(3'd6, b);   chk("R1 status read", b, 8'h01);
      chk("R9 flag cleared by read", irq_a, 0);

      // R13 chaining: A latch 1 continuous, B counts A underflows
      load_a(1);
      wr(3'd2, 8'd10); wr(3'd3, 8'd0);
      wr(3'd4, C_RUN);
      wr(3'd5, C_RUN | 8'h40);
      run_ticks(6);
      rd16(3'd2, v); chk("R13 B counts A underflows", v, 7);
      rd(3'd4, b);   chk("R6 continuous still running", b & C_RUN, C_RUN);
      wr(3'd5, C_RUN | 8'h60);
      run_ticks(4);
      rd16(3'd2, v); chk("R13 gated with pin low", v, 7);
      cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
      run_ticks(4);
      rd16(3'd2, v); chk("R13 gated with pin high", v, 5);

      // R13 timer A on pin edges, ticks ignored
      wr(3'd4, 8'h00);
      load_a(20);
      cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
      wr(3'd4, C_RUN | 8'h20);
      tick = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); cnt_pin = 1'b1;
         repeat (3) @(negedge clk); cnt_pin = 1'b0;
         repeat (3) @(negedge clk);
      end
      tick = 1'b0;
      repeat (4) @(negedge clk);
      rd16(3'd0, v); chk("R13 A pin edge count", v, 15);

      // R4/R6/R11/R9 random continuous runs on A
      wr(3'd5, 8'h00);
      for (int it = 0; it < 24; it++) begin
         int lat, n, wraps;
         lat = (it % 4 == 0) ? $urandom_range(200, 400) : $urandom_range(0, 40);
         n   = $urandom_range(0, 150);
         wr(3'd4, 8'h00);
         load_a(lat);
         rd(3'd6, b);
         wr(3'd4, C_RUN | C_PE | C_TOG);
         #1 chk("R11 toggle high on start", pb_out[0], 1);
         run_ticks(n);
         wraps = exp_wraps(lat, n);
         rd16(3'd0, v); chk("R4 counter after events", v, exp_count(lat, n));
         chk("R11 toggle level", pb_out[0], (wraps % 2 == 0) ? 1 : 0);
         rd(3'd4, b);   chk("R6 still running", b & C_RUN, C_RUN);
         rd(3'd6, b);   chk("R9 flag vs underflows", b[0], (wraps > 0) ? 1 : 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule